// File: doc/BRIEF.md
# Run-time programmable AND-OR logic array

This block is a sum-of-products array whose whole function is held in registers that can be rewritten at any time. A vector of `N_IN` inputs feeds `N_TERM` product-term rows. Each row carries a two-bit literal code for every input, and each code selects the true input, the inverted input, or no input at all. Each row also carries one connection bit per output. Every output ORs the rows connected to it. A per-output polarity flag then either passes that sum through or inverts it, so one array can produce both AND-OR and AND-OR-INVERT functions.

Configuration arrives on a single write port, one row or one polarity word per clock cycle. The stored programming can be read back on a separate combinational read port. Once a write has been registered, the outputs follow the inputs with no clock latency. After reset the array is blank: every row is unprogrammed, every output is in true polarity, and every output reads 0.

Top module: `fpla_core`

## Requirements
- R1: Literal code 2'b01 in a row makes the term require input i to be 1. The code for input i sits at bits [2i+1:2i] of the row word.
- R2: Literal code 2'b10 makes the term require input i to be 0.
- R3: Literal code 2'b11 leaves input i out of the term. A row whose codes are all 2'b11 evaluates to 1 for every input vector.
- R4: Literal code 2'b00 on any input forces the term to 0, whatever the input values.
- R5: Output j is the OR of every term whose connection bit j is set. The connection bit for output j is bit 2*N_IN+j of the row word. An output with no connected term has a sum of 0.
- R6: Polarity bit j = 0 drives the sum unchanged to output j. Polarity bit j = 1 drives the inverted sum.
- R7: While reset is asserted, every row word and every polarity bit is 0, so every output reads 0.
- R8: With `cfg_we`=1 and `cfg_sel`=0, the word on `cfg_wdata` is stored into row `cfg_addr` at the next rising clock edge. The outputs keep their old function until that edge and change combinationally after it.
- R9: With `cfg_we`=1 and `cfg_sel`=1, `cfg_wdata[N_OUT-1:0]` becomes the polarity word at the next edge, and `cfg_addr` is ignored.
- R10: A row write to an address of `N_TERM` or higher changes nothing. No state changes while `cfg_we`=0.
- R11: With `rd_sel`=0, `rd_data` returns row `rd_addr`, or 0 if that address is out of range. With `rd_sel`=1, it returns the polarity word zero-extended.
- R12: For 3 inputs (A is input 2, C is input 0), the rows AB', AC, BC in true polarity give out0=Σ(4,5,7) and out1=Σ(3,5,7). The rows B'C', A'C', A'B', ABC with out0 inverted give out0=Σ(3,5,6,7) and out1=Σ(0,2,4,7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 selects a row, 1 selects the polarity word |
| cfg_addr | input | $clog2(N_TERM) | Row index for a write |
| cfg_wdata | input | 2*N_IN+N_OUT | Row word (codes, then connection bits) or polarity word |
| rd_sel | input | 1 | Readback target: 0 selects a row, 1 selects the polarity word |
| rd_addr | input | $clog2(N_TERM) | Row index for readback |
| rd_data | output | 2*N_IN+N_OUT | Readback word |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
Both three-input example programs are swept over all eight input vectors, which separates a wrong literal decode from a wrong OR connection or a wrong polarity. One-term programs isolate each literal code: a single true, inverted, absent or unprogrammed literal on input B yields the functions B, B', constant 1 and constant 0. An output with no connected term is checked in both polarities. A polarity write is observed on the outputs one cycle before and one cycle after its clock edge, which catches an early or late update. An out-of-range row write and a write with the strobe low are checked through readback and through the outputs.

// File: rtl/fpla_pkg.sv
package fpla_pkg;

    // Two-bit literal code per input in a product-term row
    typedef enum logic [1:0] {
        LIT_OFF = 2'b00,   // unprogrammed: term is forced false
        LIT_POS = 2'b01,   // input used as is
        LIT_NEG = 2'b10,   // input used inverted
        LIT_ANY = 2'b11    // input absent from the term
    } lit_e;

    // Target of a configuration write or readback
    typedef enum logic {
        SEL_ROW = 1'b0,
        SEL_POL = 1'b1
    } cfg_sel_e;

endpackage

// File: rtl/fpla_cfg_store.sv
module fpla_cfg_store #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    localparam int DW    = 2 * N_IN + N_OUT,
    localparam int AW    = $clog2(N_TERM)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           sel,
    input  logic [AW-1:0]                  addr,
    input  logic [DW-1:0]                  wdata,
    input  logic                           rd_sel,
    input  logic [AW-1:0]                  rd_addr,
    output logic [DW-1:0]                  rd_data,
    output logic [N_TERM-1:0][DW-1:0]      rows,
    output logic [N_OUT-1:0]               pol
);
    import fpla_pkg::*;

    localparam logic [AW:0] TERM_LIM = (AW + 1)'(N_TERM);

    typedef struct packed {
        logic [N_TERM-1:0][DW-1:0] rows;
        logic [N_OUT-1:0]          pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_in_range, rd_in_range;

    assign wr_in_range = ({1'b0, addr} < TERM_LIM);
    assign rd_in_range = ({1'b0, rd_addr} < TERM_LIM);

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == SEL_POL) begin
                cfg_d.pol = wdata[N_OUT-1:0];
            end else if (wr_in_range) begin
                cfg_d.rows[addr] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_POL) begin
            rd_data[N_OUT-1:0] = cfg_q.pol;
        end else if (rd_in_range) begin
            rd_data = cfg_q.rows[rd_addr];
        end
    end

    assign rows = cfg_q.rows;
    assign pol  = cfg_q.pol;

endmodule

// File: rtl/fpla_and_plane.sv
module fpla_and_plane #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48
) (
    input  logic [N_IN-1:0]                  in_vec,
    input  logic [N_TERM-1:0][2*N_IN-1:0]    codes,
    output logic [N_TERM-1:0]                terms
);
    import fpla_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (lit_e'(codes[t][2*i +: 2]))
                    LIT_POS: if (!in_vec[i]) hit = 1'b0;
                    LIT_NEG: if (in_vec[i])  hit = 1'b0;
                    LIT_ANY: ;
                    default: hit = 1'b0;
                endcase
            end
        end
        assign terms[t] = hit;
    end

endmodule

// File: rtl/fpla_or_plane.sv
module fpla_or_plane #(
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8
) (
    input  logic [N_TERM-1:0]              terms,
    input  logic [N_TERM-1:0][N_OUT-1:0]   conn,
    input  logic [N_OUT-1:0]               pol,
    output logic [N_OUT-1:0]               out_vec
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] col;
        logic              sum;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign col[t] = conn[t][j];
        end
        assign sum        = |(terms & col);
        assign out_vec[j] = sum ^ pol[j];
    end

endmodule

// File: rtl/fpla_core.sv
module fpla_core #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    localparam int DW    = 2 * N_IN + N_OUT,
    localparam int AW    = $clog2(N_TERM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_sel,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           rd_sel,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);

    logic [N_TERM-1:0][DW-1:0]     cfg_rows;
    logic [N_OUT-1:0]              cfg_pol;
    logic [N_TERM-1:0][2*N_IN-1:0] codes;
    logic [N_TERM-1:0][N_OUT-1:0]  conn;
    logic [N_TERM-1:0]             terms;

    fpla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rows    (cfg_rows),
        .pol     (cfg_pol)
    );

    // Split every row word into its literal field and its connection field
    for (genvar t = 0; t < N_TERM; t++) begin : g_split
        assign codes[t] = cfg_rows[t][2*N_IN-1:0];
        assign conn[t]  = cfg_rows[t][DW-1:2*N_IN];
    end

    fpla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec (in_vec),
        .codes  (codes),
        .terms  (terms)
    );

    fpla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .terms   (terms),
        .conn    (conn),
        .pol     (cfg_pol),
        .out_vec (out_vec)
    );

endmodule

// File: rtl/fpla_core_chk.sv
module fpla_core_chk #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    localparam int DW    = 2 * N_IN + N_OUT,
    localparam int AW    = $clog2(N_TERM)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic                      cfg_sel,
    input logic [AW-1:0]             cfg_addr,
    input logic [DW-1:0]             cfg_wdata,
    input logic [N_TERM-1:0][DW-1:0] rows,
    input logic [N_OUT-1:0]          pol,
    input logic [N_OUT-1:0]          out_vec
);
    localparam logic [AW:0] TERM_LIM = (AW + 1)'(N_TERM);

    logic in_range;
    assign in_range = ({1'b0, cfg_addr} < TERM_LIM);

    // R7
    reset_blank_chk: assert property (@(posedge clk)
        !rst_n |-> (rows == '0 && pol == '0 && out_vec == '0));

    // R8
    row_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel && in_range) |=> rows[$past(cfg_addr)] == $past(cfg_wdata));

    // R9
    pol_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> pol == $past(cfg_wdata[N_OUT-1:0]));

    // R10
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || (!cfg_sel && !in_range)) |=> ($stable(rows) && $stable(pol)));

    // R6
    empty_array_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rows == '0) |-> out_vec == pol);

endmodule

bind fpla_core fpla_core_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rows      (cfg_rows),
    .pol       (cfg_pol),
    .out_vec   (out_vec)
);

// File: tb/fpla_core_test.sv
`timescale 1ns/1ps
module fpla_core_test;

    localparam int N_IN   = 3;
    localparam int N_TERM = 5;
    localparam int N_OUT  = 2;
    localparam int DW     = 2 * N_IN + N_OUT;
    localparam int AW     = $clog2(N_TERM);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic rd_sel = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [N_IN-1:0] in_vec = '0;
    logic [N_OUT-1:0] out_vec;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [N_IN-1:0]  stim;
        logic [N_OUT-1:0] exp;
        string            tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    fpla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_sel    (rd_sel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .in_vec    (in_vec),
        .out_vec   (out_vec)
    );

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares outputs against queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check($sformatf("%s in=%b", it.tag, it.stim), DW'(out_vec), DW'(it.exp));
            end
        end
    end

    // Driver: applies one input vector and queues the expected outputs
    task automatic drive(logic [N_IN-1:0] v, logic [N_OUT-1:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        in_vec = v;
        it.stim = v; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic sweep(logic [7:0] m0, logic [7:0] m1, string tag);
        for (int v = 0; v < 8; v++) begin
            drive(N_IN'(v), {m1[v], m0[v]}, tag);
        end
    endtask

    task automatic cfg_write(logic sel, logic [AW-1:0] a, logic [DW-1:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic check_rd(logic sel, logic [AW-1:0] a, logic [DW-1:0] e, string tag);
        @(posedge clk); #1;
        rd_sel = sel; rd_addr = a;
        @(negedge clk);
        check(tag, rd_data, e);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // Row word layout: {conn[1:0], codeA, codeB, codeC}; 01 true, 10 inverted, 11 absent, 00 off
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7: blank after reset
        sweep(8'h00, 8'h00, "R7 reset outputs");
        check_rd(1'b0, 3'd0, 8'h00, "R7 row0 cleared");
        check_rd(1'b1, 3'd0, 8'h00, "R7 polarity true");

        // R12 first example
        cfg_write(1'b0, 3'd0, {2'b01, 6'b01_10_11});
        cfg_write(1'b0, 3'd1, {2'b11, 6'b01_11_01});
        cfg_write(1'b0, 3'd2, {2'b10, 6'b11_01_01});
        sweep(8'b1011_0000, 8'b1010_1000, "R12 example one");
        check_rd(1'b0, 3'd1, {2'b11, 6'b01_11_01}, "R11 row1 readback");

        // R10: out-of-range write and strobe-low data are ignored
        cfg_write(1'b0, 3'd6, 8'hFF);
        @(posedge clk); #1;
        cfg_sel = 1'b0; cfg_addr = 3'd0; cfg_wdata = 8'hFF;
        @(posedge clk); #1;
        check_rd(1'b0, 3'd0, {2'b01, 6'b01_10_11}, "R10 row0 unchanged");
        check_rd(1'b0, 3'd6, 8'h00, "R11 out-of-range read");
        sweep(8'b1011_0000, 8'b1010_1000, "R10 function unchanged");

        // R8/R9: polarity write lands exactly at the clock edge, address ignored
        @(posedge clk); #1;
        in_vec = 3'b000;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 3'd3; cfg_wdata = 8'h03;
        @(negedge clk);
        check("R8 before edge", DW'(out_vec), DW'(2'b00));
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
        check("R9 after edge", DW'(out_vec), DW'(2'b11));
        check_rd(1'b1, 3'd0, 8'h03, "R11 polarity readback");

        // R12 second example
        cfg_write(1'b0, 3'd0, {2'b11, 6'b11_10_10});
        cfg_write(1'b0, 3'd1, {2'b11, 6'b10_11_10});
        cfg_write(1'b0, 3'd2, {2'b01, 6'b10_10_11});
        cfg_write(1'b0, 3'd3, {2'b10, 6'b01_01_01});
        cfg_write(1'b1, 3'd0, 8'h01);
        sweep(8'b1110_1000, 8'b1001_0101, "R12 example two");

        // Single-term programs on input B
        cfg_write(1'b0, 3'd1, 8'h00);
        cfg_write(1'b0, 3'd2, 8'h00);
        cfg_write(1'b0, 3'd3, 8'h00);
        cfg_write(1'b1, 3'd0, 8'h00);
        cfg_write(1'b0, 3'd0, {2'b01, 6'b11_11_11});
        sweep(8'hFF, 8'h00, "R3 R5 all-absent term, unconnected out1");
        cfg_write(1'b1, 3'd0, 8'h02);
        sweep(8'hFF, 8'hFF, "R6 inverted empty sum");
        cfg_write(1'b0, 3'd0, {2'b01, 6'b11_01_11});
        sweep(8'b1100_1100, 8'hFF, "R1 true literal B");
        cfg_write(1'b0, 3'd0, {2'b01, 6'b11_10_11});
        sweep(8'b0011_0011, 8'hFF, "R2 inverted literal B");
        cfg_write(1'b0, 3'd0, {2'b01, 6'b11_00_11});
        sweep(8'h00, 8'hFF, "R4 off literal B");

        @(posedge clk); @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule